// File: doc/BRIEF.md
# Test Access Port with Byte-Memory Access

This block is a serial test access port that follows the standard 16-state controller. It gives an external tester read and write access to an internal byte-wide memory through four pins: test clock, mode select, data in and data out. Beside the mandatory single-bit bypass path, three custom instructions each place their own data register between data-in and data-out. One register holds the memory address, one captures a byte read from memory, and one collects a byte to be written.

All logic runs on the test clock. A tester sets the address first. It then runs a data scan under the read instruction, which fetches the byte at capture and shifts it out. Alternatively it runs a data scan under the write instruction, which strobes the shifted byte into memory at the update step. A busy input from the slow nonvolatile store blocks memory strobes. While busy is high the controller, the instruction path and the address register keep working. The port assumes it is the only master of the memory while in use.

Top module: `jtag_mem_tap`

## Requirements
- R1: While `rst_ni` is low (asynchronous), the controller is in Test-Logic-Reset, `tdo_o`, `mem_rd_o` and `mem_wr_o` are 0, the address register is 00h, and bypass is selected after release.
- R2: Five consecutive rising test-clock edges with `tms_i` high bring the controller to Test-Logic-Reset from any state, and the instruction then selects bypass.
- R3: The instruction register is 4 bits, shifted LSB first, and captures 0001b in Capture-IR. It takes effect at Update-IR. Codes: 0001b address, 0010b read, 0011b write, 1111b bypass. Any other code selects bypass.
- R4: Under bypass the data path is one bit that captures 0, so a scan of N bits returns 0 followed by TDI delayed by one bit.
- R5: Under the address instruction an 8-bit LSB-first register captures the current address and drives `mem_addr_o` from Update-DR on.
- R6: Under the read instruction with busy low, `mem_rd_o` is high during Capture-DR. The byte on `mem_rdata_i` is then loaded and shifted out LSB first.
- R7: A read capture while `mem_busy_i` is high raises no strobe and loads FFh.
- R8: Under the write instruction the register captures 00h and shifts 8 bits in LSB first. During Update-DR, `mem_wr_o` is high for exactly one test-clock cycle, with the shifted byte on `mem_wdata_o`.
- R9: While `mem_busy_i` is high, a write update raises no strobe and leaves memory unchanged. Address scans and instruction scans still work.
- R10: `tdo_o` changes on falling test-clock edges only and is 0 outside Shift-IR and Shift-DR. The controller state advances on rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous test reset |
| tms_i | input | 1 | Mode select, sampled on rising test clock |
| tdi_i | input | 1 | Serial data in, sampled on rising test clock |
| tdo_o | output | 1 | Serial data out, updated on falling test clock |
| mem_addr_o | output | 8 | Memory byte address |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Byte read from memory at `mem_addr_o` |
| mem_rd_o | output | 1 | Read strobe, high during Capture-DR |
| mem_wr_o | output | 1 | Write strobe, high during Update-DR |
| mem_busy_i | input | 1 | Nonvolatile store busy; blocks memory strobes |

## Verification
The read strobe is due in the cycle whose rising edge leaves Capture-DR, which is two rising edges after leaving Run-Test/Idle. The write strobe and the new address are due in the Update-DR cycle, reached one edge after the last shifted bit. Each shifted-out bit appears on `tdo_o` at the falling edge that follows entry into the shift state. The bench therefore samples every output half a period after each falling edge, before the next rising edge, and tags each sample with the state that the preceding edges produced.

// File: rtl/jtag_mem_pkg.sv
`timescale 1ns/1ps
package jtag_mem_pkg;
  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SHF_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SHF_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {SEL_BYP, SEL_ADDR, SEL_RD, SEL_WR} dr_sel_e;
endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import jtag_mem_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    case (state_q)
      TLR:     state_d = tms_i ? TLR    : RTI;
      RTI:     state_d = tms_i ? SEL_DR : RTI;
      SEL_DR:  state_d = tms_i ? SEL_IR : CAP_DR;
      CAP_DR:  state_d = tms_i ? EX1_DR : SHF_DR;
      SHF_DR:  state_d = tms_i ? EX1_DR : SHF_DR;
      EX1_DR:  state_d = tms_i ? UPD_DR : PAU_DR;
      PAU_DR:  state_d = tms_i ? EX2_DR : PAU_DR;
      EX2_DR:  state_d = tms_i ? UPD_DR : SHF_DR;
      UPD_DR:  state_d = tms_i ? SEL_DR : RTI;
      SEL_IR:  state_d = tms_i ? TLR    : CAP_IR;
      CAP_IR:  state_d = tms_i ? EX1_IR : SHF_IR;
      SHF_IR:  state_d = tms_i ? EX1_IR : SHF_IR;
      EX1_IR:  state_d = tms_i ? UPD_IR : PAU_IR;
      PAU_IR:  state_d = tms_i ? EX2_IR : PAU_IR;
      EX2_IR:  state_d = tms_i ? UPD_IR : SHF_IR;
      UPD_IR:  state_d = tms_i ? SEL_DR : RTI;
      default: state_d = TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R2
  five_tms_reset_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_i && $past(tms_i) && $past(tms_i, 2) && $past(tms_i, 3) && $past(tms_i, 4))
    |=> state_q == TLR);
endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import jtag_mem_pkg::*;
#(
  parameter int unsigned       IR_W      = 4,
  parameter logic [IR_W-1:0]   CODE_ADDR = 4'b0001,
  parameter logic [IR_W-1:0]   CODE_RD   = 4'b0010,
  parameter logic [IR_W-1:0]   CODE_WR   = 4'b0011,
  parameter logic [IR_W-1:0]   CAP_VAL   = 4'b0001
) (
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  logic       tdi_i,
  output logic       ir_lsb_o,
  output dr_sel_e    sel_o
);
  localparam logic [IR_W-1:0] CODE_BYP = '1;

  logic [IR_W-1:0] ir_sr, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_sr <= '0;
      ir_q  <= CODE_BYP;
    end else begin
      case (state_i)
        TLR:     ir_q  <= CODE_BYP;
        CAP_IR:  ir_sr <= CAP_VAL;
        SHF_IR:  ir_sr <= {tdi_i, ir_sr[IR_W-1:1]};
        UPD_IR:  ir_q  <= ir_sr;
        default: ;
      endcase
    end
  end

  always_comb begin
    if      (ir_q == CODE_ADDR) sel_o = SEL_ADDR;
    else if (ir_q == CODE_RD)   sel_o = SEL_RD;
    else if (ir_q == CODE_WR)   sel_o = SEL_WR;
    else                        sel_o = SEL_BYP;
  end

  assign ir_lsb_o = ir_sr[0];

  // R2
  tlr_bypass_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $past(state_i == TLR) |-> sel_o == SEL_BYP);
endmodule

// File: rtl/mem_dr.sv
`timescale 1ns/1ps
module mem_dr
  import jtag_mem_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          tck_i,
  input  logic          rst_ni,
  input  tap_state_e    state_i,
  input  dr_sel_e       sel_i,
  input  logic          tdi_i,
  input  logic          mem_busy_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          dr_lsb_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o
);
  logic [DW-1:0] sr, addr_q;
  logic          byp_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr     <= '0;
      addr_q <= '0;
      byp_q  <= 1'b0;
    end else begin
      case (state_i)
        CAP_DR: begin
          case (sel_i)
            SEL_BYP:  byp_q <= 1'b0;
            SEL_ADDR: sr    <= addr_q;
            SEL_RD:   sr    <= mem_busy_i ? '1 : mem_rdata_i;
            default:  sr    <= '0;
          endcase
        end
        SHF_DR: begin
          if (sel_i == SEL_BYP) byp_q <= tdi_i;
          else                  sr    <= {tdi_i, sr[DW-1:1]};
        end
        UPD_DR: if (sel_i == SEL_ADDR) addr_q <= sr;
        default: ;
      endcase
    end
  end

  assign dr_lsb_o    = (sel_i == SEL_BYP) ? byp_q : sr[0];
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = sr;
  assign mem_rd_o    = (state_i == CAP_DR) && (sel_i == SEL_RD) && !mem_busy_i;
  assign mem_wr_o    = (state_i == UPD_DR) && (sel_i == SEL_WR) && !mem_busy_i;

  // R5
  addr_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$past(state_i == UPD_DR && sel_i == SEL_ADDR) |-> $stable(mem_addr_o));
  // R6
  rd_load_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    mem_rd_o |=> sr == $past(mem_rdata_i));
  // R7
  busy_rd_ff_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $past(state_i == CAP_DR && sel_i == SEL_RD && mem_busy_i) |-> sr == '1);
  // R8
  wr_single_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    mem_wr_o |=> !mem_wr_o);
endmodule

// File: rtl/jtag_mem_tap.sv
`timescale 1ns/1ps
module jtag_mem_tap
  import jtag_mem_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned IR_W = 4
) (
  input  logic          tck_i,
  input  logic          rst_ni,
  input  logic          tms_i,
  input  logic          tdi_i,
  output logic          tdo_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  input  logic          mem_busy_i
);
  tap_state_e state;
  dr_sel_e    sel;
  logic       ir_lsb, dr_lsb;

  tap_fsm u_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state)
  );

  tap_ir #(.IR_W(IR_W)) u_ir (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .tdi_i    (tdi_i),
    .ir_lsb_o (ir_lsb),
    .sel_o    (sel)
  );

  mem_dr #(.DW(DW)) u_dr (
    .tck_i       (tck_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .sel_i       (sel),
    .tdi_i       (tdi_i),
    .mem_busy_i  (mem_busy_i),
    .mem_rdata_i (mem_rdata_i),
    .dr_lsb_o    (dr_lsb),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o)
  );

  // data out launched on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)              tdo_o <= 1'b0;
    else if (state == SHF_IR) tdo_o <= ir_lsb;
    else if (state == SHF_DR) tdo_o <= dr_lsb;
    else                      tdo_o <= 1'b0;
  end

  // R10
  tdo_quiet_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(state == SHF_IR || state == SHF_DR) |-> !tdo_o);
  // R8
  wr_from_update_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    mem_wr_o |-> ($past(state) == EX1_DR || $past(state) == EX2_DR));
endmodule

// File: tb/sim_jtag_mem_tap.sv
`timescale 1ns/1ps
module sim_jtag_mem_tap;
  logic       tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0, busy = 1'b0;
  logic       tdo, rd, wr;
  logic [7:0] addr, wdata, rdata;
  logic [7:0] mem [256];

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic       s_tdo, s_rd, s_wr;
  logic [7:0] s_wd, s_ad;
  logic [3:0] ir_cap;
  logic [7:0] dr_out, wd_upd;
  logic       rd_cap, wr_upd;

  always #2.5 tck = ~tck;

  jtag_mem_tap u0 (
    .tck_i(tck), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi), .tdo_o(tdo),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .mem_rd_o(rd), .mem_wr_o(wr), .mem_busy_i(busy)
  );

  assign rdata = mem[addr];
  always @(posedge tck) if (wr) mem[addr] <= wdata;

  typedef struct packed {
    logic [1:0] op;   // 0 address, 1 write, 2 read
    logic [7:0] dat;
    logic       bsy;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd0, 8'h10, 1'b0, 8'h00},
    '{2'd2, 8'h00, 1'b0, 8'hEF},
    '{2'd1, 8'h3C, 1'b0, 8'h00},
    '{2'd2, 8'h00, 1'b0, 8'h3C},
    '{2'd0, 8'h81, 1'b1, 8'h10},
    '{2'd2, 8'h00, 1'b1, 8'hFF},
    '{2'd1, 8'h55, 1'b1, 8'h00},
    '{2'd2, 8'h00, 1'b0, 8'h7E},
    '{2'd1, 8'hC3, 1'b0, 8'h00},
    '{2'd2, 8'h00, 1'b0, 8'hC3}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck); #1;
    s_tdo = tdo; s_rd = rd; s_wr = wr; s_wd = wdata; s_ad = addr;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic scan_ir(input logic [3:0] code);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, code[i]);
      ir_cap[i] = s_tdo;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input logic [7:0] din);
    step(1, 0); step(0, 0); step(0, 0);
    rd_cap = s_rd;
    for (int i = 0; i < 8; i++) begin
      step(i == 7, din[i]);
      dr_out[i] = s_tdo;
    end
    step(1, 0); step(0, 0);
    wr_upd = s_wr; wd_upd = s_wd;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = ~i[7:0];
    repeat (3) @(posedge tck);
    #1;
    // R1 reset state
    chk("R1 tdo", {7'd0, tdo}, 8'h00);
    chk("R1 strobes", {6'd0, rd, wr}, 8'h00);
    chk("R1 addr", addr, 8'h00);
    @(negedge tck); rst_n = 1'b1;
    step(0, 0);
    // R10 idle data out
    step(0, 0);
    chk("R10 tdo idle", {7'd0, s_tdo}, 8'h00);
    // R4 bypass after reset
    scan_dr(8'hB4);
    chk("R4 bypass", dr_out, 8'h68);
    chk("R4 no read", {7'd0, rd_cap}, 8'h00);
    // R3 unknown code selects bypass
    scan_ir(4'b0111);
    chk("R3 ir capture", {4'd0, ir_cap}, 8'h01);
    scan_dr(8'h3C);
    chk("R3 unknown code bypass", dr_out, 8'h78);

    foreach (VECS[k]) begin
      case (VECS[k].op)
        2'd0: begin
          scan_ir(4'b0001);
          chk("R3 ir capture", {4'd0, ir_cap}, 8'h01);
          busy = VECS[k].bsy;
          scan_dr(VECS[k].dat);
          busy = 1'b0;
          chk("R5 R9 addr capture", dr_out, VECS[k].exp);
          chk("R5 R9 addr drive", addr, VECS[k].dat);
        end
        2'd1: begin
          scan_ir(4'b0011);
          busy = VECS[k].bsy;
          scan_dr(VECS[k].dat);
          busy = 1'b0;
          chk("R8 write capture", dr_out, VECS[k].exp);
          chk("R8 R9 write strobe", {7'd0, wr_upd}, {7'd0, !VECS[k].bsy});
          if (!VECS[k].bsy) chk("R8 write data", wd_upd, VECS[k].dat);
        end
        default: begin
          scan_ir(4'b0010);
          busy = VECS[k].bsy;
          scan_dr(8'h00);
          busy = 1'b0;
          chk("R6 R7 read data", dr_out, VECS[k].exp);
          chk("R6 R7 read strobe", {7'd0, rd_cap}, {7'd0, !VECS[k].bsy});
        end
      endcase
    end

    // R2 five TMS highs return to bypass
    scan_ir(4'b0010);
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
    scan_dr(8'h96);
    chk("R2 bypass after tms reset", dr_out, 8'h2C);
    chk("R2 no read strobe", {7'd0, rd_cap}, 8'h00);

    // R1 asynchronous reset during a shift
    scan_ir(4'b0001);
    step(1, 1); step(0, 1); step(0, 1);
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async addr clear", addr, 8'h00);
    chk("R1 async tdo", {7'd0, tdo}, 8'h00);
    @(negedge tck); rst_n = 1'b1;
    step(0, 0);
    scan_dr(8'h01);
    chk("R1 bypass after reset", dr_out, 8'h02);
    step(0, 0);
    chk("R10 tdo idle end", {7'd0, s_tdo}, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule